// File: doc/BRIEF.md
# Receive FIFO with Enable-Gated Control Register

This block is the receive-side buffer of one UART channel, together with the write-only control word that configures it. Bytes completed by the receive deserializer enter on a valid strobe. The host takes them out through a read strobe, and the byte appears on a registered data output. The block reports the current fill count, a threshold flag for the selected receive trigger level, and a sticky overrun flag.

The control word has one master bit that turns the FIFOs on. Every other field of a write is taken only when that same write also sets the master bit. A write that sets both the master bit and the receive-flush bit empties the receive storage for that one cycle only; the request is not stored. With the master bit off, the storage keeps at most one byte, like a plain holding register. A change of the master bit in either direction empties the storage.

Top module: `rx_fifo_ctl`

## Requirements
- R1: After reset: `fifo_en_o`=0, `dma_mode_o`=0, both trigger selects 0, `level_o`=0, `trig_o`=0, `overrun_o`=0, `rd_data_o`=0.
- R2: A control write with bit 0 = 1 sets `fifo_en_o`=1 and loads `dma_mode_o` from bit 3, `tx_trig_sel_o` from bits 5:4 and `rx_trig_sel_o` from bits 7:6. The outputs change after the edge that takes the write.
- R3: A control write with bit 0 = 0 clears `fifo_en_o` and leaves the DMA bit and both trigger selects unchanged. Bit 1 of such a write has no effect on the stored bytes.
- R4: A control write with bits 1 and 0 both set empties the receive storage and clears the overrun flag in that cycle. A byte presented on the same cycle becomes the only entry. The flush request is not held, so later bytes accumulate normally.
- R5: A control write that changes the value of the enable bit empties the receive storage and clears the overrun flag.
- R6: While enabled, up to DEPTH (64) bytes are stored and read back in arrival order. `level_o` counts from 0 to 64.
- R7: While disabled, at most one byte is stored.
- R8: A byte that arrives when the storage is at capacity, with no read in the same cycle, is dropped, and `overrun_o` is set until the next flush. If a read falls in the same cycle, the incoming byte is accepted.
- R9: A read while `level_o`=0 leaves `rd_data_o` and `level_o` unchanged.
- R10: `trig_o` = (`level_o` >= threshold). While enabled, `rx_trig_sel_o` 0,1,2,3 selects a threshold of 1, DEPTH/4, DEPTH/2 or DEPTH−DEPTH/8 (1, 16, 32, 56). While disabled, the threshold is 1.
- R11: A read with `level_o`>0 puts the oldest byte on `rd_data_o` and lowers `level_o` by one, both after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word value |
| rx_valid_i | input | 1 | Byte from the deserializer is valid |
| rx_byte_i | input | 8 | Byte from the deserializer |
| rd_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Last byte read |
| level_o | output | 7 | Bytes currently stored |
| trig_o | output | 1 | Level at or above the receive threshold |
| overrun_o | output | 1 | Sticky: a byte was dropped |
| fifo_en_o | output | 1 | FIFOs enabled |
| dma_mode_o | output | 1 | DMA mode select |
| tx_trig_sel_o | output | 2 | Transmit trigger select |
| rx_trig_sel_o | output | 2 | Receive trigger select |

## Verification
Two pairs of operations can fall in the same cycle. The first is an incoming byte together with a host read while the storage is full. The second is an incoming byte together with a flush write. The bench fills the FIFO to 64 entries and then drives valid and read in one cycle. It expects the oldest byte on the read port, a level that stays at 64, and the new byte read back last. For the second pair, it drives a flush write and a byte together and expects a level of exactly 1, with that byte returned by the next read. For each of the four receive trigger selects, the bench also sweeps every fill level from 0 to 64 and back down, and checks the flag against the threshold it computes itself.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic [1:0] rx_trig;
    logic [1:0] tx_trig;
    logic       dma;
    logic       en;
  } ctl_t;

  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - depth / 8;
    endcase
  endfunction
endpackage

// File: rtl/rxf_ctl_reg.sv
module rxf_ctl_reg
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output ctl_t       ctl_o,
  output logic       flush_o
);
  ctl_t ctl_q;
  logic unused_bit2;
  assign unused_bit2 = wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_i) begin
      ctl_q.en <= wdata_i[0];
      if (wdata_i[0]) begin
        ctl_q.dma     <= wdata_i[3];
        ctl_q.tx_trig <= wdata_i[5:4];
        ctl_q.rx_trig <= wdata_i[7:6];
      end
    end
  end

  // flush on gated reset request or any enable change; never stored
  assign flush_o = wr_i & ((wdata_i[0] & wdata_i[1]) | (wdata_i[0] != ctl_q.en));
  assign ctl_o   = ctl_q;

  p_gated_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wdata_i[0] |=> $stable(ctl_q.dma) && $stable(ctl_q.tx_trig) && $stable(ctl_q.rx_trig) && !ctl_q.en);

  p_program_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[0] |=> ctl_q.en && ctl_q.dma == $past(wdata_i[3]) && ctl_q.rx_trig == $past(wdata_i[7:6]));
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          cap1_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [LW-1:0] level_o,
  output logic          ovr_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q;
  logic [LW-1:0] level_q, cap;
  logic [DW-1:0] dout_q;
  logic          ovr_q, pop_ok, push_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap     = cap1_i ? LW'(1) : FULL;
  assign pop_ok  = pop_i & (level_q != '0) & ~flush_i;
  assign push_ok = push_i & (flush_i | (level_q < cap) | pop_ok);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[flush_i ? '0 : wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      level_q <= '0;
      ovr_q   <= 1'b0;
      dout_q  <= '0;
    end else if (flush_i) begin
      rptr_q  <= '0;
      wptr_q  <= push_i ? AW'(1) : '0;
      level_q <= push_i ? LW'(1) : '0;
      ovr_q   <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok) begin
        rptr_q <= nxt(rptr_q);
        dout_q <= mem[rptr_q];
      end
      unique case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (push_i && !push_ok) ovr_q <= 1'b1;
    end
  end

  assign dout_o  = dout_q;
  assign level_o = level_q;
  assign ovr_o   = ovr_q;

  p_level_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) level_q <= FULL);

  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap1_i && !flush_i |-> level_q <= LW'(1));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !flush_i && level_q == cap |=> level_q == $past(level_q) && ovr_q);

  p_empty_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !flush_i && level_q == '0 |=> $stable(dout_q) && level_q == $past(level_q) + LW'($past(push_i)));

  p_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !push_i |=> level_q == '0 && !ovr_q);
endmodule

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [7:0]    ctl_wdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [LW-1:0] level_o,
  output logic          trig_o,
  output logic          overrun_o,
  output logic          fifo_en_o,
  output logic          dma_mode_o,
  output logic [1:0]    tx_trig_sel_o,
  output logic [1:0]    rx_trig_sel_o
);
  import rxf_pkg::*;

  ctl_t          ctl;
  logic          flush;
  logic [LW-1:0] level, thr;

  rxf_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl),
    .flush_o (flush)
  );

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .cap1_i  (~ctl.en),
    .push_i  (rx_valid_i),
    .din_i   (rx_byte_i),
    .pop_i   (rd_i),
    .dout_o  (rd_data_o),
    .level_o (level),
    .ovr_o   (overrun_o)
  );

  assign thr           = ctl.en ? LW'(trig_level(ctl.rx_trig, DEPTH)) : LW'(1);
  assign trig_o        = level >= thr;
  assign level_o       = level;
  assign fifo_en_o     = ctl.en;
  assign dma_mode_o    = ctl.dma;
  assign tx_trig_sel_o = ctl.tx_trig;
  assign rx_trig_sel_o = ctl.rx_trig;

  p_enable_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i && !rx_valid_i && (ctl_wdata_i[0] != fifo_en_o) |=> level_o == '0 && !overrun_o);
endmodule

// File: tb/rx_fifo_ctl_bench.sv
`timescale 1ns/1ps
module rx_fifo_ctl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_wr_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [6:0] level_o;
  logic       trig_o, overrun_o, fifo_en_o, dma_mode_o;
  logic [1:0] tx_trig_sel_o, rx_trig_sel_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk_i = ~clk_i;

  rx_fifo_ctl u_rx_fifo_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .level_o(level_o), .trig_o(trig_o), .overrun_o(overrun_o), .fifo_en_o(fifo_en_o),
    .dma_mode_o(dma_mode_o), .tx_trig_sel_o(tx_trig_sel_o), .rx_trig_sel_o(rx_trig_sel_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, wait one full cycle, release
  task automatic step(input logic p, input logic [7:0] d, input logic r,
                      input logic w, input logic [7:0] wd);
    rx_valid_i = p; rx_byte_i = d; rd_i = r; ctl_wr_i = w; ctl_wdata_i = wd;
    @(negedge clk_i);
    rx_valid_i = 1'b0; rd_i = 1'b0; ctl_wr_i = 1'b0;
  endtask

  function automatic int thr_of(input int sel, input int en);
    if (en == 0) return 1;
    case (sel)
      0: return 1;
      1: return 16;
      2: return 32;
      default: return 56;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int k, input int sel);
    return 8'((k * 37 + sel * 11) & 255);
  endfunction

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 en", fifo_en_o, 0); chk("R1 dma", dma_mode_o, 0);
    chk("R1 txsel", tx_trig_sel_o, 0); chk("R1 rxsel", rx_trig_sel_o, 0);
    chk("R1 level", level_o, 0); chk("R1 trig", trig_o, 0);
    chk("R1 ovr", overrun_o, 0); chk("R1 data", rd_data_o, 0);

    // R7 disabled: single byte
    step(1, 8'hA5, 0, 0, 0);
    chk("R7 level", level_o, 1); chk("R10 trig disabled", trig_o, 1);
    step(1, 8'h5A, 0, 0, 0);
    chk("R7 level held", level_o, 1); chk("R8 ovr disabled", overrun_o, 1);
    // R3 gated writes
    step(0, 0, 0, 1, 8'h02);
    chk("R3 rxreset ignored level", level_o, 1);
    step(0, 0, 0, 1, 8'hFA);
    chk("R3 dma", dma_mode_o, 0); chk("R3 txsel", tx_trig_sel_o, 0);
    chk("R3 rxsel", rx_trig_sel_o, 0); chk("R3 en", fifo_en_o, 0);
    chk("R3 level", level_o, 1);
    step(0, 0, 1, 0, 0);
    chk("R11 data", rd_data_o, 8'hA5); chk("R11 level", level_o, 0);
    step(0, 0, 1, 0, 0);
    chk("R9 data", rd_data_o, 8'hA5); chk("R9 level", level_o, 0);

    // R2 programming; R5 enable change clears overrun
    step(1, 8'h11, 0, 0, 0);
    chk("R7 pre", level_o, 1);
    step(0, 0, 0, 1, 8'hC9);
    chk("R2 en", fifo_en_o, 1); chk("R2 dma", dma_mode_o, 1);
    chk("R2 txsel", tx_trig_sel_o, 0); chk("R2 rxsel", rx_trig_sel_o, 3);
    chk("R5 level", level_o, 0); chk("R5 ovr", overrun_o, 0);
    step(0, 0, 0, 1, 8'h21);
    chk("R2 dma2", dma_mode_o, 0); chk("R2 txsel2", tx_trig_sel_o, 2);
    chk("R2 rxsel2", rx_trig_sel_o, 0);

    // R6/R8/R10/R11 sweep for every receive threshold
    for (int sel = 0; sel < 4; sel++) begin
      step(1, 8'h99, 0, 0, 0);
      step(0, 0, 0, 1, 8'((sel << 6) | 3));
      chk("R4 flush", level_o, 0); chk("R10 trig at 0", trig_o, 0);
      for (int k = 1; k <= 64; k++) begin
        step(1, pat(k, sel), 0, 0, 0);
        chk("R6 level fill", level_o, k);
        chk("R10 trig fill", trig_o, int'(k >= thr_of(sel, 1)));
      end
      chk("R8 ovr clear", overrun_o, 0);
      step(1, 8'hEE, 0, 0, 0);
      chk("R8 full level", level_o, 64); chk("R8 ovr", overrun_o, 1);
      step(1, 8'h77, 1, 0, 0);
      chk("R8 same-cycle data", rd_data_o, pat(1, sel));
      chk("R8 same-cycle level", level_o, 64); chk("R8 ovr sticky", overrun_o, 1);
      for (int k = 2; k <= 65; k++) begin
        step(0, 0, 1, 0, 0);
        chk("R11 order", rd_data_o, (k == 65) ? 8'h77 : pat(k, sel));
        chk("R11 level drain", level_o, 65 - k);
        chk("R10 trig drain", trig_o, int'((65 - k) >= thr_of(sel, 1)));
      end
      step(0, 0, 1, 0, 0);
      chk("R9 empty data", rd_data_o, 8'h77); chk("R9 empty level", level_o, 0);
    end

    // R4 flush with same-cycle byte, self-clearing
    step(1, 8'h01, 0, 0, 0);
    step(1, 8'h02, 0, 0, 0);
    step(1, 8'h03, 0, 0, 0);
    chk("R4 pre", level_o, 3);
    step(1, 8'h42, 0, 1, 8'h03);
    chk("R4 flush+byte level", level_o, 1); chk("R4 ovr", overrun_o, 0);
    step(1, 8'h43, 0, 0, 0);
    chk("R4 self-clear", level_o, 2);
    step(0, 0, 1, 0, 0);
    chk("R4 first", rd_data_o, 8'h42);
    step(0, 0, 1, 0, 0);
    chk("R4 second", rd_data_o, 8'h43);

    // R5 disable flushes; re-enable flushes
    step(1, 8'h10, 0, 0, 0);
    step(1, 8'h20, 0, 0, 0);
    step(0, 0, 0, 1, 8'h00);
    chk("R5 disable en", fifo_en_o, 0); chk("R5 disable level", level_o, 0);
    step(1, 8'h30, 0, 0, 0);
    step(0, 0, 0, 1, 8'h01);
    chk("R5 enable level", level_o, 0); chk("R5 enable en", fifo_en_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule